// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the write port of a byte-wide, 512K-by-8 parallel flash and its memory-array back end. It watches the stream of write strobes, each carrying a 19-bit address and a data byte, and follows the multi-write unlock sequences that the flash uses to guard its destructive operations. When a byte-program or a sector-erase sequence completes, it sends a single-cycle request to the back end. The request is dropped without any trace if the targeted sector is write-locked.

Two active-low lock pins set the hardware protection. One guards the boot sector, which is the highest 64 KB sector. The other guards every remaining sector. Both pins are captured once as reset ends. The decoder also tracks an identification mode. While that mode is active, a read of the identification address returns a status byte that shows the captured lock states. While reset is held low, the block issues nothing and does not drive its read data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, `prog_req`, `erase_req` and `rdata_oe` are 0. After release, the decoder is idle and not in identification mode. A sequence cut short by reset does not complete.
- R2: Four writes complete a program: AA to 5555h, 55 to 2AAAh, A0 to 5555h, then the target address and byte. One cycle after the fourth write, `prog_req` is 1 for exactly one cycle, with `req_addr` and `req_data` equal to that write's address and data.
- R3: Six writes complete an erase: AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, then 30 to any address. One cycle later, `erase_req` pulses for one cycle. `req_addr` then holds the sector base: bits 18..16 of the sixth write's address, with bits 15..0 set to zero.
- R4: Only address bits 14..0 are compared against 5555h and 2AAAh. Bits 18..15 of unlock writes have no effect.
- R5: A write that does not match the next expected step returns the decoder to idle, and no request follows.
- R6: If `boot_lock_n` was low when reset ended, program and erase requests for sector 7 (address bits 18..16 = 7) are suppressed.
- R7: If `wr_prot_n` was low when reset ended, program and erase requests for sectors 0 to 6 are suppressed.
- R8: The lock pins are sampled on the first clock after reset release. Later changes to them have no effect until the next reset.
- R9: AA@5555h, 55@2AAAh, 90@5555h enters identification mode. In that mode, with `rd_en` high and `addr` = 7FFF2h, `rdata_oe` is 1 in the same cycle. `rdata` then has bit 2 = boot sector locked, bit 3 = other sectors locked, and all other bits 0. Any other read leaves `rdata_oe` at 0. Two writes each leave the mode: F0 to any address written from idle, or AA@5555h, 55@2AAAh, F0@5555h.
- R10: A write presented while `busy` is 1 is ignored and does not disturb a sequence in progress.
- R11: `prog_req` and `erase_req` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 19 | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| boot_lock_n | input | 1 | Boot sector lock pin, low locks |
| wr_prot_n | input | 1 | Non-boot sector lock pin, low locks |
| busy | input | 1 | Back end servicing a request |
| prog_req | output | 1 | Program request pulse |
| erase_req | output | 1 | Sector erase request pulse |
| req_addr | output | 19 | Target address of the request |
| req_data | output | 8 | Byte to program |
| rdata | output | 8 | Identification status byte |
| rdata_oe | output | 1 | Decoder drives `rdata` |

## Verification
The assertions assume that `busy` rises only after a request and that a write is a single-cycle strobe. They also assume the lock pins are stable around reset release, because the lock properties relate requests to the captured lock state. The stimulus changes lock pins only while reset is asserted, or well after release when R8 is being tested. It raises `busy` only in directed windows, with no write sequence pending a request.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_UNLK1,
      SEQ_UNLK2,
      SEQ_PROG,
      SEQ_ERS3,
      SEQ_ERS4,
      SEQ_ERS5
   } seq_state_e;

   localparam logic [7:0] CODE_UNLK1  = 8'hAA;
   localparam logic [7:0] CODE_UNLK2  = 8'h55;
   localparam logic [7:0] CODE_PROG   = 8'hA0;
   localparam logic [7:0] CODE_ERSPRE = 8'h80;
   localparam logic [7:0] CODE_ERSGO  = 8'h30;
   localparam logic [7:0] CODE_IDIN   = 8'h90;
   localparam logic [7:0] CODE_IDOUT  = 8'hF0;
   localparam logic [14:0] ADDR_KEY_A = 15'h5555;
   localparam logic [14:0] ADDR_KEY_B = 15'h2AAA;
endpackage

// File: rtl/flash_lock_latch.sv
module flash_lock_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_lock_n,
   input  logic wr_prot_n,
   output logic boot_low,
   output logic wp_low,
   output logic taken
);
   logic taken_q;
   logic boot_q;
   logic wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q <= 1'b0;
         boot_q  <= 1'b0;
         wp_q    <= 1'b0;
      end else if (!taken_q) begin
         taken_q <= 1'b1;
         boot_q  <= !boot_lock_n;
         wp_q    <= !wr_prot_n;
      end
   end

   // Before the capture edge the live pins stand in for the latched value.
   assign boot_low = taken_q ? boot_q : !boot_lock_n;
   assign wp_low   = taken_q ? wp_q   : !wr_prot_n;
   assign taken    = taken_q;
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int CMP_BITS = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              prog_hit,
   output logic              erase_hit,
   output logic              id_mode
);
   seq_state_e st_q, st_nxt;
   logic       id_q, id_nxt;
   logic       at_a, at_b, take;

   assign take = wr_en && !busy;
   assign at_a = addr[CMP_BITS-1:0] == CMP_BITS'(ADDR_KEY_A);
   assign at_b = addr[CMP_BITS-1:0] == CMP_BITS'(ADDR_KEY_B);

   function automatic logic is_code(input logic [DATA_W-1:0] d, input logic [7:0] c);
      return d == DATA_W'(c);
   endfunction

   always_comb begin
      st_nxt    = st_q;
      id_nxt    = id_q;
      prog_hit  = 1'b0;
      erase_hit = 1'b0;
      if (take) begin
         case (st_q)
            SEQ_IDLE: begin
               if (at_a && is_code(wdata, CODE_UNLK1)) st_nxt = SEQ_UNLK1;
               else if (is_code(wdata, CODE_IDOUT))    id_nxt = 1'b0;
            end
            SEQ_UNLK1:
               st_nxt = (at_b && is_code(wdata, CODE_UNLK2)) ? SEQ_UNLK2 : SEQ_IDLE;
            SEQ_UNLK2: begin
               st_nxt = SEQ_IDLE;
               if (at_a) begin
                  if (is_code(wdata, CODE_PROG))        st_nxt = SEQ_PROG;
                  else if (is_code(wdata, CODE_ERSPRE)) st_nxt = SEQ_ERS3;
                  else if (is_code(wdata, CODE_IDIN))   id_nxt = 1'b1;
                  else if (is_code(wdata, CODE_IDOUT))  id_nxt = 1'b0;
               end
            end
            SEQ_PROG: begin
               st_nxt   = SEQ_IDLE;
               prog_hit = 1'b1;
            end
            SEQ_ERS3:
               st_nxt = (at_a && is_code(wdata, CODE_UNLK1)) ? SEQ_ERS4 : SEQ_IDLE;
            SEQ_ERS4:
               st_nxt = (at_b && is_code(wdata, CODE_UNLK2)) ? SEQ_ERS5 : SEQ_IDLE;
            SEQ_ERS5: begin
               st_nxt    = SEQ_IDLE;
               erase_hit = is_code(wdata, CODE_ERSGO);
            end
            default: st_nxt = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SEQ_IDLE;
         id_q <= 1'b0;
      end else begin
         st_q <= st_nxt;
         id_q <= id_nxt;
      end
   end

   assign id_mode = id_q;
endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard #(
   parameter int ADDR_W    = 19,
   parameter int SECT_BITS = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              boot_low,
   input  logic              wp_low,
   output logic              blocked
);
   localparam int NUM_SECT  = 1 << SECT_BITS;
   localparam int BOOT_SECT = NUM_SECT - 1;

   logic [NUM_SECT-1:0]  lock_vec;
   logic [SECT_BITS-1:0] sect;

   assign sect = addr[ADDR_W-1 -: SECT_BITS];

   for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
      if (s == BOOT_SECT) begin : g_boot
         assign lock_vec[s] = boot_low;
      end else begin : g_main
         assign lock_vec[s] = wp_low;
      end
   end

   assign blocked = lock_vec[sect];
endmodule

// File: rtl/flash_req_issue.sv
module flash_req_issue #(
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 8,
   parameter int SECT_BITS   = 3,
   parameter bit ERASE_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_go,
   input  logic              erase_go,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              prog_req,
   output logic              erase_req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data
);
   localparam int OFS_W = ADDR_W - SECT_BITS;

   logic [ADDR_W-1:0] erase_addr;

   if (ERASE_ALIGN) begin : g_align
      assign erase_addr = {addr[ADDR_W-1 -: SECT_BITS], {OFS_W{1'b0}}};
   end else begin : g_raw
      assign erase_addr = addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_req  <= 1'b0;
         erase_req <= 1'b0;
         req_addr  <= '0;
         req_data  <= '0;
      end else begin
         prog_req  <= prog_go;
         erase_req <= erase_go;
         if (prog_go) begin
            req_addr <= addr;
            req_data <= wdata;
         end else if (erase_go) begin
            req_addr <= erase_addr;
            req_data <= '0;
         end
      end
   end
endmodule

// File: rtl/flash_id_port.sv
module flash_id_port #(
   parameter int              ADDR_W  = 19,
   parameter int              DATA_W  = 8,
   parameter logic [ADDR_W-1:0] ID_ADDR = 19'h7FFF2
) (
   input  logic              rst_n,
   input  logic              id_mode,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              boot_low,
   input  logic              wp_low,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);
   assign rdata_oe = rst_n && id_mode && rd_en && (addr == ID_ADDR);

   always_comb begin
      rdata = '0;
      if (rdata_oe) begin
         rdata[2] = boot_low;
         rdata[3] = wp_low;
      end
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 8,
   parameter int SECT_BITS   = 3,
   parameter int CMP_BITS    = 15,
   parameter bit ERASE_ALIGN = 1'b1,
   parameter logic [ADDR_W-1:0] ID_ADDR = 19'h7FFF2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              boot_lock_n,
   input  logic              wr_prot_n,
   input  logic              busy,
   output logic              prog_req,
   output logic              erase_req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold an 8-bit command code");
   end
   if (CMP_BITS < 15 || CMP_BITS > ADDR_W - SECT_BITS) begin : g_bad_cmp
      $error("CMP_BITS must cover the unlock keys and sit below the sector bits");
   end
   if (SECT_BITS < 1) begin : g_bad_sect
      $error("SECT_BITS must be at least 1");
   end

   logic boot_low, wp_low, lock_taken;
   logic prog_hit, erase_hit, id_mode, blocked;

   flash_lock_latch u_lock (
      .clk(clk), .rst_n(rst_n),
      .boot_lock_n(boot_lock_n), .wr_prot_n(wr_prot_n),
      .boot_low(boot_low), .wp_low(wp_low), .taken(lock_taken)
   );

   flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_BITS(CMP_BITS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
      .addr(addr), .wdata(wdata),
      .prog_hit(prog_hit), .erase_hit(erase_hit), .id_mode(id_mode)
   );

   flash_sector_guard #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_guard (
      .addr(addr), .boot_low(boot_low), .wp_low(wp_low), .blocked(blocked)
   );

   flash_req_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS),
                     .ERASE_ALIGN(ERASE_ALIGN)) u_issue (
      .clk(clk), .rst_n(rst_n),
      .prog_go(prog_hit && !blocked), .erase_go(erase_hit && !blocked),
      .addr(addr), .wdata(wdata),
      .prog_req(prog_req), .erase_req(erase_req),
      .req_addr(req_addr), .req_data(req_data)
   );

   flash_id_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_ADDR(ID_ADDR)) u_id (
      .rst_n(rst_n), .id_mode(id_mode), .rd_en(rd_en), .addr(addr),
      .boot_low(boot_low), .wp_low(wp_low),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
   parameter int ADDR_W    = 19,
   parameter int SECT_BITS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              busy,
   input logic              prog_req,
   input logic              erase_req,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rdata_oe,
   input logic              boot_low,
   input logic              wp_low,
   input logic              lock_taken
);
   localparam logic [SECT_BITS-1:0] BOOT = '1;

   logic [SECT_BITS-1:0] rsect;
   assign rsect = req_addr[ADDR_W-1 -: SECT_BITS];

   always_comb begin
      if (!rst_n) begin
         AST_OE_IN_RESET: assert (!rdata_oe); // R1
      end
   end

   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_req && erase_req)); // R11
   AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req); // R2
   AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req); // R3
   AST_PROG_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> $past(wr_en && !busy)); // R10
   AST_ERASE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> $past(wr_en && !busy)); // R10
   AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      ((prog_req || erase_req) && rsect == BOOT) |-> !boot_low); // R6
   AST_MAIN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      ((prog_req || erase_req) && rsect != BOOT) |-> !wp_low); // R7
   AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      lock_taken |=> ($stable(boot_low) && $stable(wp_low))); // R8
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
   .prog_req(prog_req), .erase_req(erase_req), .req_addr(req_addr),
   .rdata_oe(rdata_oe), .boot_low(boot_low), .wp_low(wp_low),
   .lock_taken(lock_taken)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0;
   logic [18:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        boot_lock_n = 1'b1, wr_prot_n = 1'b1;
   logic        prog_req, erase_req, rdata_oe;
   logic [18:0] req_addr;
   logic [7:0]  req_data, rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic        g_prog, g_erase;
   logic [18:0] g_addr;
   logic [7:0]  g_data;
   logic        lk_boot, lk_wp;   // expected latched lock pins (active low)

   always #4 clk = ~clk;

   flash_cmd_decoder u_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .boot_lock_n(boot_lock_n), .wr_prot_n(wr_prot_n),
      .busy(busy), .prog_req(prog_req), .erase_req(erase_req),
      .req_addr(req_addr), .req_data(req_data), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic bit exp_blocked(input logic [18:0] a);
      return (a[18:16] == 3'd7) ? !lk_boot : !lk_wp;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [18:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      g_prog = prog_req; g_erase = erase_req; g_addr = req_addr; g_data = req_data;
   endtask

   task automatic unlock();
      wr(19'h05555, 8'hAA);
      wr(19'h02AAA, 8'h55);
   endtask

   task automatic do_prog(input logic [18:0] a, input logic [7:0] d);
      unlock();
      wr(19'h05555, 8'hA0);
      wr(a, d);
   endtask

   task automatic do_erase(input logic [18:0] a);
      unlock();
      wr(19'h05555, 8'h80);
      unlock();
      wr(a, 8'h30);
   endtask

   task automatic id_read(input logic [18:0] a, output logic oe, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      #1;
      oe = rdata_oe; d = rdata;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic do_reset(input logic bl, input logic wp);
      logic oe;
      @(negedge clk);
      rst_n = 1'b0;
      boot_lock_n = bl; wr_prot_n = wp;
      lk_boot = bl; lk_wp = wp;
      addr = 19'h7FFF2; rd_en = 1'b1;
      tick(); tick();
      oe = rdata_oe;
      chk(oe == 1'b0 && prog_req == 1'b0 && erase_req == 1'b0, "R1 outputs idle in reset",
          {prog_req, erase_req, oe}, 0);
      rd_en = 1'b0;
      rst_n = 1'b1;
      tick();
   endtask

   task automatic expect_prog(input logic [18:0] a, input logic [7:0] d, input bit want, input string req);
      if (want)
         chk(g_prog && !g_erase && g_addr == a && g_data == d, req,
             {g_prog, g_erase, g_addr, g_data}, {1'b1, 1'b0, a, d});
      else
         chk(!g_prog && !g_erase, req, {g_prog, g_erase}, 0);
   endtask

   task automatic expect_erase(input logic [18:0] a, input bit want, input string req);
      logic [18:0] base;
      base = {a[18:16], 16'h0};
      if (want)
         chk(g_erase && !g_prog && g_addr == base, req, {g_prog, g_erase, g_addr}, {1'b0, 1'b1, base});
      else
         chk(!g_prog && !g_erase, req, {g_prog, g_erase}, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=%h exp=%h", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic        oe;
      logic [7:0]  d;
      void'($urandom(32'd5174));

      // R1 reset, unlocked
      do_reset(1'b1, 1'b1);
      id_read(19'h7FFF2, oe, d);
      chk(oe == 1'b0, "R1 not in id mode after reset", oe, 0);

      // R2 program
      do_prog(19'h31234, 8'h5A);
      expect_prog(19'h31234, 8'h5A, 1'b1, "R2 program request");
      tick();
      chk(prog_req == 1'b0, "R2 program pulse one cycle", prog_req, 0);

      // R3 erase
      do_erase(19'h50007);
      expect_erase(19'h50007, 1'b1, "R3 erase request");
      tick();
      chk(erase_req == 1'b0, "R3 erase pulse one cycle", erase_req, 0);

      // R4 upper address bits ignored in unlock compare
      wr(19'h7D555, 8'hAA);
      wr(19'h12AAA, 8'h55);
      wr(19'h45555, 8'hA0);
      wr(19'h20042, 8'hC3);
      expect_prog(19'h20042, 8'hC3, 1'b1, "R4 upper bits ignored");

      // R5 mismatches
      unlock();
      wr(19'h05555, 8'h77);
      wr(19'h10001, 8'h11);
      expect_prog(19'h10001, 8'h11, 1'b0, "R5 wrong command byte");
      wr(19'h05555, 8'hAA);
      wr(19'h02AAB, 8'h55);
      wr(19'h05555, 8'hA0);
      wr(19'h10002, 8'h22);
      expect_prog(19'h10002, 8'h22, 1'b0, "R5 wrong unlock address");
      unlock();
      wr(19'h05555, 8'h80);
      unlock();
      wr(19'h30000, 8'h31);
      expect_erase(19'h30000, 1'b0, "R5 wrong erase confirm");

      // R10 busy writes ignored mid-sequence
      unlock();
      busy = 1'b1;
      wr(19'h01234, 8'h11);
      busy = 1'b0;
      wr(19'h05555, 8'hA0);
      wr(19'h60010, 8'h99);
      expect_prog(19'h60010, 8'h99, 1'b1, "R10 busy write ignored");
      busy = 1'b1;
      do_prog(19'h60020, 8'h98);
      busy = 1'b0;
      expect_prog(19'h60020, 8'h98, 1'b0, "R10 no request while busy");

      // R9 identification mode
      unlock();
      wr(19'h05555, 8'h90);
      id_read(19'h7FFF2, oe, d);
      chk(oe == 1'b1 && d == 8'h00, "R9 id read unlocked", {oe, d}, {1'b1, 8'h00});
      id_read(19'h7FFF0, oe, d);
      chk(oe == 1'b0, "R9 other address not driven", oe, 0);
      wr(19'h12345, 8'hF0);
      id_read(19'h7FFF2, oe, d);
      chk(oe == 1'b0, "R9 single-write exit", oe, 0);
      unlock();
      wr(19'h05555, 8'h90);
      unlock();
      wr(19'h05555, 8'hF0);
      id_read(19'h7FFF2, oe, d);
      chk(oe == 1'b0, "R9 three-write exit", oe, 0);

      // R1 reset cuts a sequence
      unlock();
      wr(19'h05555, 8'hA0);
      do_reset(1'b1, 1'b1);
      wr(19'h10003, 8'h33);
      expect_prog(19'h10003, 8'h33, 1'b0, "R1 reset aborts sequence");

      // R6 boot locked
      do_reset(1'b0, 1'b1);
      do_prog(19'h70100, 8'h44);
      expect_prog(19'h70100, 8'h44, 1'b0, "R6 boot program blocked");
      do_erase(19'h7ABCD);
      expect_erase(19'h7ABCD, 1'b0, "R6 boot erase blocked");
      do_prog(19'h20100, 8'h45);
      expect_prog(19'h20100, 8'h45, 1'b1, "R6 other sector allowed");
      unlock();
      wr(19'h05555, 8'h90);
      id_read(19'h7FFF2, oe, d);
      chk(oe && d == 8'h04, "R9 id read boot locked", d, 8'h04);
      wr(19'h00000, 8'hF0);

      // R8 pin changes after capture have no effect
      boot_lock_n = 1'b1; wr_prot_n = 1'b0;
      tick();
      do_prog(19'h70200, 8'h46);
      expect_prog(19'h70200, 8'h46, 1'b0, "R8 boot lock held");
      do_erase(19'h00000);
      expect_erase(19'h00000, 1'b1, "R8 write protect not taken late");

      // R7 main sectors locked
      do_reset(1'b1, 1'b0);
      for (int s = 0; s < 8; s++) begin
         do_erase({s[2:0], 16'h0100});
         expect_erase({s[2:0], 16'h0100}, s == 7, "R7 sector erase lock");
      end
      unlock();
      wr(19'h05555, 8'h90);
      id_read(19'h7FFF2, oe, d);
      chk(oe && d == 8'h08, "R9 id read main locked", d, 8'h08);
      wr(19'h00000, 8'hF0);

      // random mix, R2 R3 R5 R6 R7 R11
      for (int i = 0; i < 240; i++) begin
         logic [18:0] a;
         logic [7:0]  dv;
         if (i % 60 == 0) do_reset($urandom_range(0, 1), $urandom_range(0, 1));
         a  = 19'($urandom);
         dv = 8'($urandom);
         if ($urandom_range(0, 3) == 0) wr(19'($urandom), 8'h13);
         if ($urandom_range(0, 1) == 0) begin
            do_prog(a, dv);
            expect_prog(a, dv, !exp_blocked(a), "R2 random program");
         end else begin
            do_erase(a);
            expect_erase(a, !exp_blocked(a), "R3 random erase");
         end
         chk(!(g_prog && g_erase), "R11 exclusive requests", {g_prog, g_erase}, 0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule